// File: doc/BRIEF.md
# Byte Load/Store Memory Execution Unit

This unit executes one family of byte-moving instructions. Each instruction copies a single byte between a working register and either program memory or data memory. Once a start pulse arrives with the opcode, the unit asks for the remaining instruction bytes one at a time from a fetch port. It reads a register pair from an external 16-entry working register file and forms a 16-bit effective address. It then performs the one-byte transfer and signals completion with a single-cycle done pulse. Each format has a fixed cycle count, whatever its operand values.

The two nibbles of the operand byte give a register number and a register-pair field. A load (opcode bit 4 = 0) puts the register number in the upper nibble and the pair field in the lower nibble. A store (opcode bit 4 = 1) swaps the two. The memory space comes from bit 0 of the pair field: 0 selects program memory and 1 selects data memory. It does not come from the opcode. The pair that is actually read is the field with bit 0 cleared. The even register gives the high address byte and the odd register gives the low address byte.

Top module: `ldmem_unit`

## Requirements
- R1: While reset is held and after it is released with no start, busy, done, badOp, fetchReq, rfWe, pmWe and dmWe are all low.
- R2: Opcodes 0xC3 (load) and 0xD3 (store) fetch one operand byte and use the pair value itself as the address. They complete in 10 cycles.
- R3: Opcodes 0xE7 (load) and 0xF7 (store) fetch the operand byte and then one offset byte. The offset is sign-extended and added to the pair value modulo 65536. They complete in 12 cycles.
- R4: Opcodes 0xA7 (load) and 0xB7 (store) with a pair field of 2..15 fetch the operand byte, then the offset low byte, then the offset high byte. The 16-bit offset is added to the pair value modulo 65536. They complete in 14 cycles.
- R5: Opcodes 0xA7/0xB7 with a pair field of 0 or 1 use direct addressing. The address is {third fetched byte, second fetched byte} and no pair is involved. They complete in 14 cycles.
- R6: For loads the register number is operand bits [7:4] and the pair field is bits [3:0]. For stores the register number is bits [3:0] and the pair field is bits [7:4].
- R7: Pair-field bit 0 equal to 0 selects program memory (pmRe/pmWe). Bit 0 equal to 1 selects data memory (dmRe/dmWe). The base is {rf[field with bit 0 cleared], rf[field with bit 0 set]}.
- R8: A load writes the selected memory byte into the named register with exactly one rfWe pulse, and it issues no memory write.
- R9: A store issues exactly one write strobe, to the selected space only, carrying the named register's value on memWdata. It issues no register write.
- R10: Count the cycle in which start is sampled as cycle 1. Then busy is high in cycles 2 through N, and done is high only in cycle N, for one cycle.
- R11: A start with any other opcode is not executed. badOp pulses in the next cycle, and busy, fetchReq and all write strobes stay low.
- R12: A start pulse while busy is high is ignored. The running instruction finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| opcode | input | 8 | Opcode accompanying start |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| badOp | output | 1 | Pulse after a start with an unsupported opcode |
| fetchReq | output | 1 | Next instruction byte is consumed this cycle |
| fetchData | input | 8 | Instruction byte from the fetch side |
| rfAddr | output | 4 | Working register index |
| rfRdata | input | 8 | Working register read data (combinational) |
| rfWe | output | 1 | Working register write strobe |
| rfWdata | output | 8 | Working register write data |
| memAddr | output | 16 | Effective address, shared by both spaces |
| pmRe | output | 1 | Program memory read strobe |
| pmWe | output | 1 | Program memory write strobe |
| pmRdata | input | 8 | Program memory read data (combinational) |
| dmRe | output | 1 | Data memory read strobe |
| dmWe | output | 1 | Data memory write strobe |
| dmRdata | input | 8 | Data memory read data (combinational) |
| memWdata | output | 8 | Store data for either space |

## Verification
The bench covers all four addressing shapes in both directions, with odd and even pair fields. A unit that chose the space from the opcode, or that failed to clear the pair's low bit, would send the access to the wrong port or the wrong address. A negative short offset and a long offset that wraps past 0xFFFF catch a missing sign extension or a carry lost at 16 bits. Pair fields 0 and 1 on the wide opcodes must switch to direct addressing. A unit that still added the register pair would give a wrong address, and a unit that skipped the wait would finish early. An unknown opcode and a start while busy must leave the fetch count, the write strobes and the done timing untouched.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  localparam logic [7:0] OP_IND_LD   = 8'hC3;
  localparam logic [7:0] OP_IND_ST   = 8'hD3;
  localparam logic [7:0] OP_SHORT_LD = 8'hE7;
  localparam logic [7:0] OP_SHORT_ST = 8'hF7;
  localparam logic [7:0] OP_WIDE_LD  = 8'hA7;
  localparam logic [7:0] OP_WIDE_ST  = 8'hB7;

  typedef enum logic [1:0] {
    MODE_IND,
    MODE_SHORT,
    MODE_LONG,
    MODE_DIRECT
  } addrMode_t;

  typedef enum logic [1:0] {
    FAM_IND,
    FAM_SHORT,
    FAM_WIDE
  } opFam_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      ldOpnd;
    logic      ldX1;
    logic      ldX2;
    logic      rdHi;
    logic      rdLo;
    logic      xfer;
    logic      isStore;
    addrMode_t mode;
  } dpCtl_t;

endpackage

// File: rtl/ldm_ctrl.sv
module ldm_ctrl
  import ldm_pkg::*;
#(
  parameter int CYC_IND   = 10,
  parameter int CYC_SHORT = 12,
  parameter int CYC_WIDE  = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       pairIsLow,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       done,
  output logic       badOp,
  output logic       fetchReq
);

  localparam int CW = $clog2(CYC_WIDE + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPND, ST_X1, ST_X2, ST_HI, ST_LO, ST_XFER, ST_HOLD
  } state_t;

  state_t        state, nextState;
  opFam_t        fam, newFam;
  logic          isStore;
  logic          validOp;
  logic [CW-1:0] cnt;
  logic [CW-1:0] total;

  always_comb begin
    validOp = 1'b1;
    newFam  = FAM_IND;
    case (opcode)
      OP_IND_LD,   OP_IND_ST:   newFam = FAM_IND;
      OP_SHORT_LD, OP_SHORT_ST: newFam = FAM_SHORT;
      OP_WIDE_LD,  OP_WIDE_ST:  newFam = FAM_WIDE;
      default:                  validOp = 1'b0;
    endcase
  end

  always_comb begin
    case (fam)
      FAM_IND:   total = CW'(CYC_IND);
      FAM_SHORT: total = CW'(CYC_SHORT);
      default:   total = CW'(CYC_WIDE);
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = busy && (cnt == total);

  always_comb begin
    nextState = state;
    case (state)
      ST_OPND: nextState = (fam == FAM_IND) ? ST_HI : ST_X1;
      ST_X1:   nextState = (fam == FAM_SHORT) ? ST_HI : ST_X2;
      ST_X2:   nextState = pairIsLow ? ST_XFER : ST_HI;
      ST_HI:   nextState = ST_LO;
      ST_LO:   nextState = ST_XFER;
      ST_XFER: nextState = ST_HOLD;
      default: nextState = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fam     <= FAM_IND;
      isStore <= 1'b0;
      cnt     <= '0;
      badOp   <= 1'b0;
    end else begin
      badOp <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          if (validOp) begin
            state   <= ST_OPND;
            fam     <= newFam;
            isStore <= opcode[4];
            cnt     <= CW'(2);
          end else begin
            badOp <= 1'b1;
          end
        end
      end else if (done) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        state <= nextState;
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assign fetchReq = (state == ST_OPND) || (state == ST_X1) || (state == ST_X2);

  always_comb begin
    ctl.ldOpnd  = (state == ST_OPND);
    ctl.ldX1    = (state == ST_X1);
    ctl.ldX2    = (state == ST_X2);
    ctl.rdHi    = (state == ST_HI);
    ctl.rdLo    = (state == ST_LO);
    ctl.xfer    = (state == ST_XFER);
    ctl.isStore = isStore;
    case (fam)
      FAM_IND:   ctl.mode = MODE_IND;
      FAM_SHORT: ctl.mode = MODE_SHORT;
      default:   ctl.mode = pairIsLow ? MODE_DIRECT : MODE_LONG;
    endcase
  end

endmodule

// File: rtl/ldm_dpath.sv
module ldm_dpath
  import ldm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         ctl,
  input  logic [DW-1:0]  fetchData,
  output logic           pairIsLow,
  output logic [RAW-1:0] rfAddr,
  input  logic [DW-1:0]  rfRdata,
  output logic           rfWe,
  output logic [DW-1:0]  rfWdata,
  output logic [AW-1:0]  memAddr,
  output logic           pmRe,
  output logic           pmWe,
  input  logic [DW-1:0]  pmRdata,
  output logic           dmRe,
  output logic           dmWe,
  input  logic [DW-1:0]  dmRdata,
  output logic [DW-1:0]  memWdata
);

  localparam int EXT = AW - DW;

  logic [DW-1:0]  opnd, x1, x2, baseHi, baseLo;
  logic [RAW-1:0] regNib, pairNib;
  logic [AW-1:0]  base, offset;
  logic           toData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opnd   <= '0;
      x1     <= '0;
      x2     <= '0;
      baseHi <= '0;
      baseLo <= '0;
    end else begin
      if (ctl.ldOpnd) opnd   <= fetchData;
      if (ctl.ldX1)   x1     <= fetchData;
      if (ctl.ldX2)   x2     <= fetchData;
      if (ctl.rdHi)   baseHi <= rfRdata;
      if (ctl.rdLo)   baseLo <= rfRdata;
    end
  end

  assign regNib    = ctl.isStore ? opnd[RAW-1:0] : opnd[DW-1:RAW];
  assign pairNib   = ctl.isStore ? opnd[DW-1:RAW] : opnd[RAW-1:0];
  assign pairIsLow = (pairNib[RAW-1:1] == '0);
  assign toData    = pairNib[0];

  always_comb begin
    if (ctl.rdHi)      rfAddr = {pairNib[RAW-1:1], 1'b0};
    else if (ctl.rdLo) rfAddr = {pairNib[RAW-1:1], 1'b1};
    else               rfAddr = regNib;
  end

  always_comb begin
    base   = {baseHi, baseLo};
    offset = '0;
    case (ctl.mode)
      MODE_SHORT:  offset = {{EXT{x1[DW-1]}}, x1};
      MODE_LONG:   offset = {x2, x1};
      MODE_DIRECT: begin
        base   = '0;
        offset = {x2, x1};
      end
      default: offset = '0;
    endcase
  end

  assign memAddr  = base + offset;
  assign pmRe     = ctl.xfer && !ctl.isStore && !toData;
  assign dmRe     = ctl.xfer && !ctl.isStore &&  toData;
  assign pmWe     = ctl.xfer &&  ctl.isStore && !toData;
  assign dmWe     = ctl.xfer &&  ctl.isStore &&  toData;
  assign memWdata = rfRdata;
  assign rfWe     = ctl.xfer && !ctl.isStore;
  assign rfWdata  = toData ? dmRdata : pmRdata;

endmodule

// File: rtl/ldmem_unit.sv
module ldmem_unit
  import ldm_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int RAW       = 4,
  parameter int CYC_IND   = 10,
  parameter int CYC_SHORT = 12,
  parameter int CYC_WIDE  = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [DW-1:0]  opcode,
  output logic           busy,
  output logic           done,
  output logic           badOp,
  output logic           fetchReq,
  input  logic [DW-1:0]  fetchData,
  output logic [RAW-1:0] rfAddr,
  input  logic [DW-1:0]  rfRdata,
  output logic           rfWe,
  output logic [DW-1:0]  rfWdata,
  output logic [AW-1:0]  memAddr,
  output logic           pmRe,
  output logic           pmWe,
  input  logic [DW-1:0]  pmRdata,
  output logic           dmRe,
  output logic           dmWe,
  input  logic [DW-1:0]  dmRdata,
  output logic [DW-1:0]  memWdata
);

  dpCtl_t ctl;
  logic   pairIsLow;

  ldm_ctrl #(
    .CYC_IND(CYC_IND), .CYC_SHORT(CYC_SHORT), .CYC_WIDE(CYC_WIDE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .pairIsLow(pairIsLow), .ctl(ctl), .busy(busy), .done(done),
    .badOp(badOp), .fetchReq(fetchReq)
  );

  ldm_dpath #(.AW(AW), .DW(DW), .RAW(RAW)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fetchData(fetchData),
    .pairIsLow(pairIsLow), .rfAddr(rfAddr), .rfRdata(rfRdata),
    .rfWe(rfWe), .rfWdata(rfWdata), .memAddr(memAddr),
    .pmRe(pmRe), .pmWe(pmWe), .pmRdata(pmRdata),
    .dmRe(dmRe), .dmWe(dmWe), .dmRdata(dmRdata), .memWdata(memWdata)
  );

endmodule

// File: rtl/ldmem_unit_chk.sv
module ldmem_unit_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic badOp,
  input logic fetchReq,
  input logic rfWe,
  input logic pmWe,
  input logic dmWe
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!fetchReq && !rfWe && !pmWe && !dmWe));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r9_one_write: assert property (@(posedge clk) disable iff (!rstN)
    (pmWe || dmWe) |=> !(pmWe || dmWe));

  a_r9_space_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(pmWe && dmWe));

  a_r8_no_mix: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> !(pmWe || dmWe));

  a_r11_bad_idle: assert property (@(posedge clk) disable iff (!rstN)
    badOp |-> !busy);

  a_r12_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

bind ldmem_unit ldmem_unit_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .badOp(badOp), .fetchReq(fetchReq), .rfWe(rfWe), .pmWe(pmWe), .dmWe(dmWe)
);

// File: tb/tb_ldmem_unit.sv
`timescale 1ns/1ps
module tb_ldmem_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        busy, done, badOp, fetchReq;
  logic [7:0]  fetchData;
  logic [3:0]  rfAddr;
  logic [7:0]  rfRdata;
  logic        rfWe;
  logic [7:0]  rfWdata;
  logic [15:0] memAddr;
  logic        pmRe, pmWe, dmRe, dmWe;
  logic [7:0]  pmRdata, dmRdata, memWdata;

  always #2 clk = ~clk;

  ldmem_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .busy(busy), .done(done), .badOp(badOp), .fetchReq(fetchReq),
    .fetchData(fetchData), .rfAddr(rfAddr), .rfRdata(rfRdata),
    .rfWe(rfWe), .rfWdata(rfWdata), .memAddr(memAddr),
    .pmRe(pmRe), .pmWe(pmWe), .pmRdata(pmRdata),
    .dmRe(dmRe), .dmWe(dmWe), .dmRdata(dmRdata), .memWdata(memWdata)
  );

  // Bench models: register file, memories, fetch side
  logic [7:0] rf [16];
  logic [7:0] fb [4];
  logic [1:0] fIdx = 2'd0;

  function automatic logic [7:0] pmByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] dmByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rfRdata   = rf[rfAddr];
  assign pmRdata   = pmByte(memAddr);
  assign dmRdata   = dmByte(memAddr);
  assign fetchData = fb[fIdx];

  int nFetch = 0, nPmWe = 0, nDmWe = 0, nRfWe = 0;
  logic [15:0] wAddr = '0;
  logic [7:0]  wData = '0, rfWD = '0;
  logic [3:0]  rfWA = '0;

  always @(posedge clk) begin
    if (start && !busy) fIdx <= 2'd0;
    else if (fetchReq && fIdx != 2'd3) fIdx <= fIdx + 2'd1;
    if (rstN) begin
      if (fetchReq) nFetch <= nFetch + 1;
      if (pmWe) begin nPmWe <= nPmWe + 1; wAddr <= memAddr; wData <= memWdata; end
      if (dmWe) begin nDmWe <= nDmWe + 1; wAddr <= memAddr; wData <= memWdata; end
      if (rfWe) begin nRfWe <= nRfWe + 1; rfWA <= rfAddr; rfWD <= rfWdata; end
    end
  end

  int errs = 0, nChecks = 0;
  bit finished = 0;

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Runs one instruction; busyStartAt>0 raises a stray start in that cycle
  task automatic runInstr(input logic [7:0] op, b2, b3, b4, input int busyStartAt,
                          output int doneAt, output int doneCnt, output int busyCnt);
    fb[0] = b2; fb[1] = b3; fb[2] = b4; fb[3] = 8'h00;
    doneAt = 0; doneCnt = 0; busyCnt = 0;
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(posedge clk);
    for (int n = 2; n <= 17; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        if (doneAt == 0) doneAt = n;
        doneCnt++;
      end
      if (busy) busyCnt++;
      if (n == busyStartAt) begin start = 1'b1; opcode = 8'hA7; end
    end
    start = 1'b0;
  endtask

  // {op, b2, b3, b4, cycles, isData, addr}
  localparam int NV = 11;
  localparam logic [63:0] VEC [NV] = '{
    {8'hC3, 8'h52, 8'h00, 8'h00, 8'd10, 8'd0, 16'h2D3C},
    {8'hC3, 8'h7B, 8'h00, 8'h00, 8'd10, 8'd1, 16'hA5B4},
    {8'hD3, 8'h49, 8'h00, 8'h00, 8'd10, 8'd0, 16'h4B5A},
    {8'hC3, 8'h01, 8'h00, 8'h00, 8'd10, 8'd1, 16'h0F1E},
    {8'hE7, 8'h3D, 8'h80, 8'h00, 8'd12, 8'd1, 16'hC352},
    {8'hF7, 8'hE1, 8'h20, 8'h00, 8'd12, 8'd0, 16'hE210},
    {8'hA7, 8'h26, 8'h34, 8'h12, 8'd14, 8'd0, 16'h7BAC},
    {8'hB7, 8'h9C, 8'h00, 8'h80, 8'd14, 8'd1, 16'h0796},
    {8'hA7, 8'h40, 8'hCD, 8'hAB, 8'd14, 8'd0, 16'hABCD},
    {8'hB7, 8'h1F, 8'h78, 8'h56, 8'd14, 8'd1, 16'h5678},
    {8'hA7, 8'h81, 8'hFF, 8'hFF, 8'd14, 8'd1, 16'hFFFF}
  };

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = {4'(i), 4'(15 - i)};
    fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R1", "busy in reset", busy, 0);
    checkEq("R1", "done/badOp/fetchReq in reset", {done, badOp, fetchReq}, 0);
    checkEq("R1", "write strobes in reset", {rfWe, pmWe, dmWe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R1", "idle after reset", {busy, done, fetchReq, rfWe, pmWe, dmWe}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  op, b2, b3, b4;
      logic [15:0] expAddr;
      int expN, isData, isStore, regIdx, f0, pw0, dw0, rw0, dAt, dCnt, bCnt;
      string tag;
      op = VEC[v][63:56]; b2 = VEC[v][55:48]; b3 = VEC[v][47:40]; b4 = VEC[v][39:32];
      expN = int'(VEC[v][31:24]); isData = int'(VEC[v][16]); expAddr = VEC[v][15:0];
      isStore = int'(op[4]);
      regIdx = isStore != 0 ? int'(b2[3:0]) : int'(b2[7:4]);   // R6 nibble placement
      if (expN == 10) tag = "R2";
      else if (expN == 12) tag = "R3";
      else if ((isStore != 0 ? b2[7:5] : b2[3:1]) == 3'd0) tag = "R5";
      else tag = "R4";
      f0 = nFetch; pw0 = nPmWe; dw0 = nDmWe; rw0 = nRfWe;
      runInstr(op, b2, b3, b4, 0, dAt, dCnt, bCnt);
      checkEq(tag, "done cycle", dAt, expN);
      checkEq("R10", "done pulse count", dCnt, 1);
      checkEq("R10", "busy cycles", bCnt, expN - 1);
      checkEq(tag, "bytes fetched", nFetch - f0, expN == 10 ? 1 : (expN == 12 ? 2 : 3));
      if (isStore != 0) begin
        checkEq("R7", "pm write count", nPmWe - pw0, isData != 0 ? 0 : 1);
        checkEq("R7", "dm write count", nDmWe - dw0, isData != 0 ? 1 : 0);
        checkEq(tag, "store address", wAddr, expAddr);
        checkEq("R9", "store data (R6 reg)", wData, rf[regIdx]);
        checkEq("R9", "no reg write on store", nRfWe - rw0, 0);
      end else begin
        checkEq("R8", "reg write count", nRfWe - rw0, 1);
        checkEq("R6", "reg written", rfWA, regIdx);
        checkEq("R7", "load data by space/address",
                rfWD, isData != 0 ? dmByte(expAddr) : pmByte(expAddr));
        checkEq("R8", "no mem write on load", (nPmWe - pw0) + (nDmWe - dw0), 0);
      end
      checkEq("R10", "idle after done", busy, 0);
    end

    // R11: unsupported opcode
    begin
      int f0, w0;
      f0 = nFetch; w0 = nPmWe + nDmWe + nRfWe;
      @(negedge clk);
      start = 1'b1; opcode = 8'h00;
      @(negedge clk);
      start = 1'b0;
      checkEq("R11", "badOp pulse", badOp, 1);
      checkEq("R11", "busy after bad op", busy, 0);
      @(negedge clk);
      checkEq("R11", "badOp single", badOp, 0);
      repeat (4) @(negedge clk);
      checkEq("R11", "no fetch/write after bad op", (nFetch - f0) + (nPmWe + nDmWe + nRfWe - w0), 0);
    end

    // R12: start while busy is ignored
    begin
      int f0, r0, dAt, dCnt, bCnt;
      f0 = nFetch; r0 = nRfWe;
      runInstr(8'hC3, 8'h52, 8'h00, 8'h00, 4, dAt, dCnt, bCnt);
      checkEq("R12", "done cycle with stray start", dAt, 10);
      checkEq("R12", "done count with stray start", dCnt, 1);
      checkEq("R12", "fetch count with stray start", nFetch - f0, 1);
      checkEq("R12", "reg writes with stray start", nRfWe - r0, 1);
      checkEq("R12", "load data with stray start", rfWD, pmByte(16'h2D3C));
      checkEq("R12", "idle after", busy, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, nChecks);
      $finish;
    end
  end

endmodule